// File: doc/BRIEF.md
# Maskable Interrupt Priority Arbiter

This block decides, at each instruction boundary of a small processor core, whether one of its maskable interrupt sources is taken. Each source owns a pending bit, which hardware sets when the source raises a request, and a 3-bit priority level written by software. The core owns a global enable flag and a 3-bit current processor level. A source qualifies when its pending bit is set and its level is strictly above the processor level. Among the qualifying sources the highest level wins, and on a tie the lowest index wins. A winner is taken only in a cycle that carries the boundary strobe and only while the enable flag is set.

When a source is taken, the block gives a one-cycle accept pulse together with the winning index and level, both held in registers. In the same step it clears that source's pending bit, raises the processor level to the winner's level and clears the enable flag. Any request at the same or a lower level is then held off until software or a return operation lowers the level or sets the flag again.

Changes to the enable flag follow two different timings. A return-type operation changes the flag in time for the boundary check of its own cycle. A set, clear, pop or control-load operation changes it only after one more instruction, so the boundary that follows such an operation still sees the old value.

Top module: `intr_arb_top`

## Requirements
- R1: After reset the enable flag, the processor level, every pending bit and every source level are 0, and `acc_o` is 0. A request that is raised before any level is written is never taken.
- R2: A pulse on `src_raise_i[i]` sets `pend_o[i]` in the next cycle. A hardware raise wins over a software clear or an acceptance clear of the same bit in the same cycle.
- R3: A software write (`swc_we_i`) with `swc_bit_i`=0 clears pending bit `swc_idx_i`. A write with `swc_bit_i`=1 is ignored and never creates a request.
- R4: A source is taken only in a cycle with `insn_bnd_i`=1, only when the enable value in force is 1, and only when its pending bit is 1 and its level is strictly greater than the processor level. `acc_o` rises in the cycle after that boundary and lasts one cycle.
- R5: A source whose level is 0 is never taken, whatever the processor level.
- R6: Among qualifying sources, the one with the highest level is taken; on equal levels the lowest index is taken.
- R7: In the cycle that `acc_o` is high, `acc_idx_o` and `acc_lvl_o` give the winner, the winner's pending bit is 0, `ipl_o` equals the winner's level and `ien_o` is 0. The index and level outputs hold until the next acceptance.
- R8: `flag_op_i` encodes 0 = no flag change, 1 = return-type change, 2 = deferred change, 3 = no flag change. A return-type change with value `flag_val_i` is used by the boundary check of the same cycle and shows on `ien_o` in the next cycle.
- R9: A deferred change is not used by the first boundary at or after the operation, including one in the same cycle. That boundary uses the old value and commits the new one, which `ien_o` shows from the next cycle. Every later boundary uses the new value.
- R10: Writes to a source level (`cfg_we_i`) and to the processor level (`ipl_we_i`) take effect from the next cycle. A boundary in the same cycle still uses the old values. An acceptance overrides a processor-level write in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| src_raise_i | input | NUM_SRC | One-cycle request pulses, one per source |
| swc_we_i | input | 1 | Software write to a pending bit |
| swc_idx_i | input | IDX_W | Source index of the software write |
| swc_bit_i | input | 1 | Value written; only 0 has an effect |
| cfg_we_i | input | 1 | Write enable for a source level |
| cfg_idx_i | input | IDX_W | Source index of the level write |
| cfg_lvl_i | input | LVL_W | New source level |
| ipl_we_i | input | 1 | Write enable for the processor level |
| ipl_val_i | input | LVL_W | New processor level |
| flag_op_i | input | 2 | Kind of enable-flag change (see R8) |
| flag_val_i | input | 1 | New enable-flag value |
| insn_bnd_i | input | 1 | Instruction boundary strobe |
| acc_o | output | 1 | One-cycle accept pulse |
| acc_idx_o | output | IDX_W | Index of the last accepted source |
| acc_lvl_o | output | LVL_W | Level of the last accepted source |
| ipl_o | output | LVL_W | Current processor level |
| ien_o | output | 1 | Registered global enable flag |
| pend_o | output | NUM_SRC | Pending bits |

## Verification
The assertions assume that every input is a known value once reset is released, and that the source indices on the software and level-write ports stay below NUM_SRC. They also assume that a return-type and a deferred flag change never come together, which the one-field encoding of `flag_op_i` guarantees. The bench changes inputs only at falling edges and uses only legal indices. It sweeps every pair of processor level and source level, and it drains several level patterns with ties down to the point where no source qualifies. All of its traffic stays inside these assumptions.

// File: rtl/intr_arb_pkg.sv
package intr_arb_pkg;

    // Kind of change applied to the global enable flag
    typedef enum logic [1:0] {
        FLG_NONE   = 2'd0,
        FLG_RETURN = 2'd1,   // takes effect at the boundary of this cycle
        FLG_DEFER  = 2'd2,   // takes effect one instruction later
        FLG_SPARE  = 2'd3    // treated as no change
    } flag_op_e;

endpackage

// File: rtl/intr_req_bank.sv
module intr_req_bank #(
    parameter  int NUM_SRC = 8,
    parameter  int LVL_W   = 3,
    localparam int IDX_W   = (NUM_SRC > 1) ? $clog2(NUM_SRC) : 1
) (
    input  logic                            clk,
    input  logic                            rst_n,
    input  logic [NUM_SRC-1:0]              raise_i,
    input  logic                            swc_we_i,
    input  logic [IDX_W-1:0]                swc_idx_i,
    input  logic                            swc_bit_i,
    input  logic                            cfg_we_i,
    input  logic [IDX_W-1:0]                cfg_idx_i,
    input  logic [LVL_W-1:0]                cfg_lvl_i,
    input  logic                            take_i,
    input  logic [IDX_W-1:0]                take_idx_i,
    output logic [NUM_SRC-1:0]              pend_o,
    output logic [NUM_SRC-1:0][LVL_W-1:0]   lvl_o
);

    typedef struct packed {
        logic [NUM_SRC-1:0]            pend;
        logic [NUM_SRC-1:0][LVL_W-1:0] lvl;
    } bank_st_t;

    bank_st_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (swc_we_i && !swc_bit_i) begin
            st_d.pend[swc_idx_i] = 1'b0;
        end
        if (take_i) begin
            st_d.pend[take_idx_i] = 1'b0;
        end
        st_d.pend = st_d.pend | raise_i;
        if (cfg_we_i) begin
            st_d.lvl[cfg_idx_i] = cfg_lvl_i;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign pend_o = st_q.pend;
    assign lvl_o  = st_q.lvl;

    AST_PEND_ONLY_BY_RAISE: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.pend & ~$past(st_q.pend) & ~$past(raise_i)) == '0); // R3

    AST_RAISE_SETS_PEND: assert property (@(posedge clk) disable iff (!rst_n)
        (raise_i != '0) |=> ((st_q.pend & $past(raise_i)) == $past(raise_i))); // R2

endmodule

// File: rtl/intr_pick.sv
module intr_pick #(
    parameter  int NUM_SRC = 8,
    parameter  int LVL_W   = 3,
    localparam int IDX_W   = (NUM_SRC > 1) ? $clog2(NUM_SRC) : 1
) (
    input  logic [NUM_SRC-1:0]              pend_i,
    input  logic [NUM_SRC-1:0][LVL_W-1:0]   lvl_i,
    input  logic [LVL_W-1:0]                ipl_i,
    output logic                            found_o,
    output logic [IDX_W-1:0]                idx_o,
    output logic [LVL_W-1:0]                lvl_o
);

    logic [NUM_SRC-1:0] qual;

    // A source qualifies when pending and strictly above the processor level
    for (genvar g = 0; g < NUM_SRC; g++) begin : g_qual
        assign qual[g] = pend_i[g] && (lvl_i[g] > ipl_i);
    end

    // Ascending scan with a strict compare keeps the lowest index on ties
    always_comb begin
        found_o = 1'b0;
        idx_o   = '0;
        lvl_o   = ipl_i;
        for (int i = 0; i < NUM_SRC; i++) begin
            if (qual[i] && (lvl_i[i] > lvl_o)) begin
                found_o = 1'b1;
                idx_o   = IDX_W'(i);
                lvl_o   = lvl_i[i];
            end
        end
    end

endmodule

// File: rtl/intr_flag_ctl.sv
module intr_flag_ctl
    import intr_arb_pkg::*;
(
    input  logic     clk,
    input  logic     rst_n,
    input  flag_op_e op_i,
    input  logic     val_i,
    input  logic     bnd_i,
    input  logic     take_i,
    output logic     ien_eff_o,
    output logic     ien_o
);

    typedef struct packed {
        logic ien;
        logic stg_vld;
        logic stg_val;
    } flag_st_t;

    flag_st_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (op_i == FLG_RETURN) begin
            st_d.ien     = val_i;
            st_d.stg_vld = 1'b0;
        end
        if (op_i == FLG_DEFER) begin
            st_d.stg_vld = 1'b1;
            st_d.stg_val = val_i;
        end
        // First boundary at or after a deferred change commits it
        if (bnd_i && st_d.stg_vld) begin
            st_d.ien     = st_d.stg_val;
            st_d.stg_vld = 1'b0;
        end
        if (take_i) begin
            st_d.ien     = 1'b0;
            st_d.stg_vld = 1'b0;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign ien_eff_o = (op_i == FLG_RETURN) ? val_i : st_q.ien;
    assign ien_o     = st_q.ien;

    AST_IEN_CHANGE_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(st_q.ien) |-> $past(bnd_i || (op_i == FLG_RETURN))); // R9

    AST_DEFER_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
        (op_i == FLG_DEFER && !bnd_i) |=> (st_q.ien == $past(st_q.ien))); // R9

endmodule

// File: rtl/intr_arb_top.sv
module intr_arb_top
    import intr_arb_pkg::*;
#(
    parameter  int NUM_SRC = 8,
    parameter  int LVL_W   = 3,
    localparam int IDX_W   = (NUM_SRC > 1) ? $clog2(NUM_SRC) : 1
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [NUM_SRC-1:0] src_raise_i,
    input  logic               swc_we_i,
    input  logic [IDX_W-1:0]   swc_idx_i,
    input  logic               swc_bit_i,
    input  logic               cfg_we_i,
    input  logic [IDX_W-1:0]   cfg_idx_i,
    input  logic [LVL_W-1:0]   cfg_lvl_i,
    input  logic               ipl_we_i,
    input  logic [LVL_W-1:0]   ipl_val_i,
    input  logic [1:0]         flag_op_i,
    input  logic               flag_val_i,
    input  logic               insn_bnd_i,
    output logic               acc_o,
    output logic [IDX_W-1:0]   acc_idx_o,
    output logic [LVL_W-1:0]   acc_lvl_o,
    output logic [LVL_W-1:0]   ipl_o,
    output logic               ien_o,
    output logic [NUM_SRC-1:0] pend_o
);

    typedef struct packed {
        logic             acc;
        logic [IDX_W-1:0] idx;
        logic [LVL_W-1:0] lvl;
        logic [LVL_W-1:0] ipl;
    } top_st_t;

    top_st_t                        st_d, st_q;
    logic [NUM_SRC-1:0][LVL_W-1:0]  src_lvl;
    logic                           win_found;
    logic [IDX_W-1:0]               win_idx;
    logic [LVL_W-1:0]               win_lvl;
    logic                           ien_eff;
    logic                           take_now;

    assign take_now = insn_bnd_i && ien_eff && win_found;

    intr_req_bank #(.NUM_SRC(NUM_SRC), .LVL_W(LVL_W)) bank_i (
        .clk        (clk),
        .rst_n      (rst_n),
        .raise_i    (src_raise_i),
        .swc_we_i   (swc_we_i),
        .swc_idx_i  (swc_idx_i),
        .swc_bit_i  (swc_bit_i),
        .cfg_we_i   (cfg_we_i),
        .cfg_idx_i  (cfg_idx_i),
        .cfg_lvl_i  (cfg_lvl_i),
        .take_i     (take_now),
        .take_idx_i (win_idx),
        .pend_o     (pend_o),
        .lvl_o      (src_lvl)
    );

    intr_pick #(.NUM_SRC(NUM_SRC), .LVL_W(LVL_W)) pick_i (
        .pend_i  (pend_o),
        .lvl_i   (src_lvl),
        .ipl_i   (st_q.ipl),
        .found_o (win_found),
        .idx_o   (win_idx),
        .lvl_o   (win_lvl)
    );

    intr_flag_ctl flag_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .op_i      (flag_op_e'(flag_op_i)),
        .val_i     (flag_val_i),
        .bnd_i     (insn_bnd_i),
        .take_i    (take_now),
        .ien_eff_o (ien_eff),
        .ien_o     (ien_o)
    );

    always_comb begin
        st_d     = st_q;
        st_d.acc = take_now;
        if (ipl_we_i) begin
            st_d.ipl = ipl_val_i;
        end
        if (take_now) begin
            st_d.idx = win_idx;
            st_d.lvl = win_lvl;
            st_d.ipl = win_lvl;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign acc_o     = st_q.acc;
    assign acc_idx_o = st_q.idx;
    assign acc_lvl_o = st_q.lvl;
    assign ipl_o     = st_q.ipl;

    AST_ACC_AT_BOUNDARY: assert property (@(posedge clk) disable iff (!rst_n)
        acc_o |-> $past(insn_bnd_i)); // R4

    AST_ACC_NEEDS_EN: assert property (@(posedge clk) disable iff (!rst_n)
        acc_o |-> $past(ien_eff)); // R4

    AST_ACC_WAS_PENDING: assert property (@(posedge clk) disable iff (!rst_n)
        acc_o |-> $past(pend_o[win_idx])); // R4

    AST_ACC_ABOVE_IPL: assert property (@(posedge clk) disable iff (!rst_n)
        acc_o |-> (acc_lvl_o > $past(ipl_o))); // R4

    AST_ACC_NONZERO_LVL: assert property (@(posedge clk) disable iff (!rst_n)
        acc_o |-> (acc_lvl_o != '0)); // R5

    AST_ACC_UPDATES_STATE: assert property (@(posedge clk) disable iff (!rst_n)
        acc_o |-> ((ipl_o == acc_lvl_o) && !ien_o)); // R7

    AST_ACC_CLEARS_PEND: assert property (@(posedge clk) disable iff (!rst_n)
        (acc_o && !$past(src_raise_i[win_idx])) |-> !pend_o[acc_idx_o]); // R7

endmodule

// File: tb/intr_arb_top_tb_top.sv
`timescale 1ns/1ps
module intr_arb_top_tb_top;

    localparam int NS = 8;
    localparam int LW = 3;
    localparam int IW = 3;

    logic          clk = 1'b0;
    logic          rst_n;
    logic [NS-1:0] src_raise_i;
    logic          swc_we_i;
    logic [IW-1:0] swc_idx_i;
    logic          swc_bit_i;
    logic          cfg_we_i;
    logic [IW-1:0] cfg_idx_i;
    logic [LW-1:0] cfg_lvl_i;
    logic          ipl_we_i;
    logic [LW-1:0] ipl_val_i;
    logic [1:0]    flag_op_i;
    logic          flag_val_i;
    logic          insn_bnd_i;
    logic          acc_o;
    logic [IW-1:0] acc_idx_o;
    logic [LW-1:0] acc_lvl_o;
    logic [LW-1:0] ipl_o;
    logic          ien_o;
    logic [NS-1:0] pend_o;

    int n_chk  = 0;
    int n_fail = 0;
    bit ended  = 1'b0;

    intr_arb_top #(.NUM_SRC(NS), .LVL_W(LW)) dut_i (
        .clk(clk), .rst_n(rst_n), .src_raise_i(src_raise_i),
        .swc_we_i(swc_we_i), .swc_idx_i(swc_idx_i), .swc_bit_i(swc_bit_i),
        .cfg_we_i(cfg_we_i), .cfg_idx_i(cfg_idx_i), .cfg_lvl_i(cfg_lvl_i),
        .ipl_we_i(ipl_we_i), .ipl_val_i(ipl_val_i),
        .flag_op_i(flag_op_i), .flag_val_i(flag_val_i), .insn_bnd_i(insn_bnd_i),
        .acc_o(acc_o), .acc_idx_o(acc_idx_o), .acc_lvl_o(acc_lvl_o),
        .ipl_o(ipl_o), .ien_o(ien_o), .pend_o(pend_o)
    );

    always #4 clk = ~clk;

    task automatic summary();
        if (!ended) begin
            ended = 1'b1;
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    endtask

    task automatic chk(input string tag, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    task automatic idle();
        src_raise_i = '0; swc_we_i = 1'b0; swc_idx_i = '0; swc_bit_i = 1'b0;
        cfg_we_i = 1'b0; cfg_idx_i = '0; cfg_lvl_i = '0;
        ipl_we_i = 1'b0; ipl_val_i = '0;
        flag_op_i = 2'd0; flag_val_i = 1'b0; insn_bnd_i = 1'b0;
    endtask

    // Apply the driven inputs over one rising edge, then sample after the falling edge
    task automatic tick();
        @(posedge clk);
        @(negedge clk);
        idle();
    endtask

    task automatic cfg(input int s, input int l);
        cfg_we_i = 1'b1; cfg_idx_i = IW'(s); cfg_lvl_i = LW'(l);
        tick();
    endtask

    task automatic set_ipl(input int p);
        ipl_we_i = 1'b1; ipl_val_i = LW'(p);
        tick();
    endtask

    task automatic raise(input int s);
        src_raise_i[s] = 1'b1;
        tick();
    endtask

    task automatic swc(input int s, input bit b);
        swc_we_i = 1'b1; swc_idx_i = IW'(s); swc_bit_i = b;
        tick();
    endtask

    // Boundary with a flag operation in the same cycle
    task automatic bnd(input int op, input bit v);
        insn_bnd_i = 1'b1; flag_op_i = 2'(op); flag_val_i = v;
        tick();
    endtask

    task automatic clean_all();
        for (int i = 0; i < NS; i++) begin
            swc_we_i = 1'b1; swc_idx_i = IW'(i); swc_bit_i = 1'b0;
            cfg_we_i = 1'b1; cfg_idx_i = IW'(i); cfg_lvl_i = '0;
            tick();
        end
        flag_op_i = 2'd1; flag_val_i = 1'b0;
        tick();
        set_ipl(0);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog expired");
        summary();
    end

    initial begin
        idle();
        rst_n = 1'b0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        tick();

        // R1: reset state
        chk("R1 acc", acc_o, 0);
        chk("R1 ipl", ipl_o, 0);
        chk("R1 ien", ien_o, 0);
        chk("R1 pend", pend_o, 0);
        raise(0);
        bnd(1, 1'b1);
        chk("R1 level reset 0, no accept", acc_o, 0);
        clean_all();

        // R4 R5 R7: every processor level against every source level
        for (int p = 0; p < 8; p++) begin
            for (int l = 0; l < 8; l++) begin
                int s;
                s = (p + l) % NS;
                cfg(s, l);
                set_ipl(p);
                raise(s);
                chk("R2 raise sets pend", pend_o[s], 1);
                bnd(1, 1'b1);
                if (l > p) begin
                    chk("R4 accept", acc_o, 1);
                    chk("R7 idx", acc_idx_o, s);
                    chk("R7 lvl", acc_lvl_o, l);
                    chk("R7 ipl raised", ipl_o, l);
                    chk("R7 ien cleared", ien_o, 0);
                    chk("R7 pend cleared", pend_o[s], 0);
                    tick();
                    chk("R4 single pulse", acc_o, 0);
                    chk("R7 idx held", acc_idx_o, s);
                end else begin
                    chk(l == 0 ? "R5 level 0 refused" : "R4 not above ipl", acc_o, 0);
                    chk("R4 pend kept", pend_o[s], 1);
                    chk("R8 return sets ien", ien_o, 1);
                end
                swc_we_i = 1'b1; swc_idx_i = IW'(s); swc_bit_i = 1'b0;
                cfg_we_i = 1'b1; cfg_idx_i = IW'(s); cfg_lvl_i = '0;
                flag_op_i = 2'd1; flag_val_i = 1'b0;
                tick();
            end
        end
        set_ipl(0);

        // R6: drain several level patterns, ties included
        for (int k = 0; k < 6; k++) begin
            int lv[NS];
            bit pd[NS];
            int p;
            bit done;
            p = k % 3;
            for (int i = 0; i < NS; i++) begin
                lv[i] = (i * (k + 1) + k) % 8;
                pd[i] = 1'b1;
                cfg(i, lv[i]);
            end
            src_raise_i = '1;
            tick();
            done = 1'b0;
            for (int r = 0; r <= NS && !done; r++) begin
                int best;
                int w;
                set_ipl(p);
                bnd(1, 1'b1);
                best = p; w = -1;
                for (int i = 0; i < NS; i++) begin
                    if (pd[i] && lv[i] > best) begin
                        best = lv[i]; w = i;
                    end
                end
                chk("R6 accept present", acc_o, (w >= 0) ? 1 : 0);
                if (w >= 0) begin
                    chk("R6 winner idx", acc_idx_o, w);
                    chk("R6 winner lvl", acc_lvl_o, best);
                    pd[w] = 1'b0;
                end else begin
                    done = 1'b1;
                end
            end
            clean_all();
        end

        // R9: deferred set in the same cycle as a boundary
        cfg(2, 5);
        raise(2);
        bnd(2, 1'b1);
        chk("R9 same-cycle boundary uses old", acc_o, 0);
        chk("R9 committed at boundary", ien_o, 1);
        bnd(0, 1'b0);
        chk("R9 next boundary accepts", acc_o, 1);
        chk("R9 idx", acc_idx_o, 2);
        set_ipl(0);

        // R9: deferred set between boundaries
        raise(2);
        flag_op_i = 2'd2; flag_val_i = 1'b1;
        tick();
        chk("R9 not yet applied", ien_o, 0);
        bnd(0, 1'b0);
        chk("R9 first boundary old value", acc_o, 0);
        bnd(0, 1'b0);
        chk("R9 second boundary accepts", acc_o, 1);
        set_ipl(0);

        // R9: deferred clear still lets the first boundary accept
        flag_op_i = 2'd1; flag_val_i = 1'b1;
        tick();
        chk("R8 return sets ien", ien_o, 1);
        raise(2);
        bnd(2, 1'b0);
        chk("R9 deferred clear uses old 1", acc_o, 1);
        set_ipl(0);

        // R4: enable cleared by a return in the boundary cycle
        raise(2);
        bnd(1, 1'b0);
        chk("R4 disabled no accept", acc_o, 0);
        bnd(0, 1'b0);
        chk("R4 still disabled", acc_o, 0);
        chk("R4 pend kept", pend_o[2], 1);

        // R8: code 3 is no change
        bnd(3, 1'b1);
        chk("R8 code 3 no accept", acc_o, 0);
        chk("R8 code 3 ien unchanged", ien_o, 0);

        // R10: processor-level write in the boundary cycle; accept wins
        ipl_we_i = 1'b1; ipl_val_i = 3'd7;
        insn_bnd_i = 1'b1; flag_op_i = 2'd1; flag_val_i = 1'b1;
        tick();
        chk("R10 old ipl used", acc_o, 1);
        chk("R10 accept overrides ipl write", ipl_o, 5);

        // R10: level write in the boundary cycle is not yet seen
        raise(3);
        cfg_we_i = 1'b1; cfg_idx_i = 3'd3; cfg_lvl_i = 3'd6;
        insn_bnd_i = 1'b1; flag_op_i = 2'd1; flag_val_i = 1'b1;
        tick();
        chk("R10 old level used", acc_o, 0);
        bnd(0, 1'b0);
        chk("R10 new level used", acc_o, 1);
        chk("R10 idx", acc_idx_o, 3);
        clean_all();

        // R2: raise wins over a same-cycle software clear
        src_raise_i[4] = 1'b1;
        swc_we_i = 1'b1; swc_idx_i = 3'd4; swc_bit_i = 1'b0;
        tick();
        chk("R2 raise beats clear", pend_o[4], 1);

        // R3: software clear and ignored write of 1
        swc(4, 1'b0);
        chk("R3 clear by 0", pend_o[4], 0);
        swc(4, 1'b1);
        chk("R3 write 1 ignored", pend_o[4], 0);
        cfg(4, 7);
        bnd(1, 1'b1);
        chk("R3 no request created", acc_o, 0);
        clean_all();

        summary();
    end

endmodule